// File: doc/BRIEF.md
# NAND Page Read Pointer Controller

This block is the device-side read path of a small-page NAND memory. A host writes a read command and three address bytes over the shared 8-bit bus, strobing each byte with the write strobe. The block then goes busy for a fixed page-load time. After that, the host pulls bytes out one at a time with the read strobe. Each page holds 528 bytes: columns 0 to 511 are the main area and columns 512 to 527 are a 16-byte spare area. The cell array is replaced by a computed page store, so every byte has a value that can be predicted.

The column pointer depends on the region. The two main-area commands start the read in the lower or the upper half of the main area. The spare command confines addressing to the 16 spare bytes, and it stays in force until the lower-half main command is issued. When a read passes column 527, the pointer rolls to the next page and the block goes busy again. After that busy interval it restarts at column 0, or at column 512 in spare mode. On the last page it stops at column 527 and repeats that byte.

All strobes are sampled on `clk`, active low and idle high. Data leaves as a stream of `dout` qualified by a one-cycle `dout_valid`. There is no ready input. The host applies back-pressure only by withholding read strobes: a byte is produced only when the host asks for one, so it can never be lost. `dout` holds its value between bytes.

Top module: `nand_read_ptr_ctrl`

## Requirements
- R1: During and after reset, `rb_n` is 1, `dout_valid` is 0 and `dout` is 0.
- R2: A byte is captured on a rising edge of `we_n` while `ce_n` is low. With `cle` high it is a command, and only 8'h00, 8'h01 and 8'h50 are accepted. Any other command code changes nothing, and address bytes that follow it start no read. With `ale` high it is an address byte: the column byte first, then the low row byte, then the high row byte. The low PAGE_AW bits of the 16-bit row select the page.
- R3: After command 8'h00 the start column equals the column byte. After command 8'h01 (outside spare mode) the start column is 256 plus the column byte.
- R4: After command 8'h50 the start column is 512 plus bits 3:0 of the column byte, and bits 7:4 have no effect.
- R5: Spare mode persists through later reads and through commands 8'h01 and 8'h50. Only command 8'h00 returns reads to the main area.
- R6: After the third address byte, `rb_n` is low for exactly TR_CYCLES clock cycles. Read strobes during that time produce no data and do not move the pointer.
- R7: Each falling edge of `re_n` in the ready read state gives `dout_valid` high for the one cycle after the edge. `dout` then equals the byte at (page, column), and the column advances by one. The byte at (page p, column c) is c[7:0] XOR {p[3:0], 2'b00, c[9:8]}.
- R8: A read of column 527 on any page except the last moves to the next page and makes `rb_n` low for TR_CYCLES cycles. Reading then resumes at column 512 in spare mode, or at column 0 otherwise.
- R9: On the last page, column 527 is repeated on every further read strobe, and `rb_n` stays high.
- R10: `ce_n` high ends any read or busy interval and returns to idle with `rb_n` high. Strobes while `ce_n` is high are ignored. Read strobes give no data until a new command and address complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Bus byte is a command |
| ale | input | 1 | Bus byte is an address |
| we_n | input | 1 | Write strobe; bytes captured on its rising edge |
| re_n | input | 1 | Read strobe; each falling edge requests one byte |
| io_in | input | 8 | Command/address bus |
| rb_n | output | 1 | Ready (1) / busy (0) |
| dout | output | 8 | Read data |
| dout_valid | output | 1 | `dout` carries a new byte this cycle |

## Verification
The assertions check on every cycle that no byte appears while busy or while the chip is deselected. They also check that the column never exceeds 527, that spare-mode reads never leave columns 512 to 527, and that the final address byte is followed by busy. Rollover is checked to raise busy on every page except the last. The bench scenarios are the only place that shows the exact start columns, the byte values, how long the sticky spare selection lasts, that an unknown command has no effect, the exact length of the busy interval, and the restart column after rollover.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  localparam int COL_W      = 10;
  localparam int LAST_COL   = 527;
  localparam int SPARE_BASE = 512;
  localparam int HALF_BASE  = 256;

  localparam logic [7:0] CMD_MAIN_LO = 8'h00;
  localparam logic [7:0] CMD_MAIN_HI = 8'h01;
  localparam logic [7:0] CMD_SPARE   = 8'h50;

  typedef enum logic [1:0] {RGN_MAIN_LO, RGN_MAIN_HI, RGN_SPARE} region_e;
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_READ} rd_state_e;

  function automatic logic [7:0] cell_byte(input logic [3:0] pg, input logic [COL_W-1:0] col);
    return col[7:0] ^ {pg, 2'b00, col[9:8]};
  endfunction
endpackage

// File: rtl/nand_strobe_edge.sv
module nand_strobe_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strobe_n,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b1;
      else        prev_q[i] <= strobe_n[i];
    end
    assign rise[i] = ~prev_q[i] & strobe_n[i];
    assign fall[i] = prev_q[i] & ~strobe_n[i];
  end
endmodule

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
  import nand_rd_pkg::*;
#(
  parameter int PAGE_AW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               cle,
  input  logic               ale,
  input  logic               we_rise,
  input  logic [7:0]         io_in,
  input  logic               busy,
  output logic               cmd_hit,
  output logic               start_go,
  output logic [COL_W-1:0]   start_col,
  output logic [PAGE_AW-1:0] start_page,
  output logic               spare_mode
);
  region_e     rgn_q;
  logic        armed_q;
  logic [1:0]  idx_q;
  logic [7:0]  col_q, rlo_q;
  logic        accept, cmd_ev, addr_ev, known_cmd;
  logic [15:0] row;

  assign accept    = we_rise & ~ce_n & ~busy;
  assign cmd_ev    = accept & cle & ~ale;
  assign addr_ev   = accept & ale & ~cle & armed_q;
  assign known_cmd = (io_in == CMD_MAIN_LO) || (io_in == CMD_MAIN_HI) || (io_in == CMD_SPARE);
  assign cmd_hit   = cmd_ev & known_cmd;
  assign start_go  = addr_ev & (idx_q == 2'd2);
  assign row       = {io_in, rlo_q};
  assign start_page = row[PAGE_AW-1:0];
  assign spare_mode = (rgn_q == RGN_SPARE);

  always_comb begin
    unique case (rgn_q)
      RGN_MAIN_LO: start_col = {2'b00, col_q};
      RGN_MAIN_HI: start_col = {2'b01, col_q};
      default:     start_col = {6'b100000, col_q[3:0]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgn_q   <= RGN_MAIN_LO;
      armed_q <= 1'b0;
      idx_q   <= 2'd0;
      col_q   <= 8'h00;
      rlo_q   <= 8'h00;
    end else if (ce_n) begin
      armed_q <= 1'b0;
    end else if (cmd_hit) begin
      armed_q <= 1'b1;
      idx_q   <= 2'd0;
      if (io_in == CMD_MAIN_LO)      rgn_q <= RGN_MAIN_LO;
      else if (io_in == CMD_SPARE)   rgn_q <= RGN_SPARE;
      else if (rgn_q != RGN_SPARE)   rgn_q <= RGN_MAIN_HI;
    end else if (addr_ev) begin
      if (idx_q == 2'd0) col_q <= io_in;
      if (idx_q == 2'd1) rlo_q <= io_in;
      if (idx_q == 2'd2) armed_q <= 1'b0;
      idx_q <= idx_q + 2'd1;
    end
  end
endmodule

// File: rtl/nand_col_ptr.sv
module nand_col_ptr
  import nand_rd_pkg::*;
#(
  parameter int PAGE_AW   = 2,
  parameter int TR_CYCLES = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               cmd_hit,
  input  logic               start_go,
  input  logic [COL_W-1:0]   start_col,
  input  logic [PAGE_AW-1:0] start_page,
  input  logic               spare_mode,
  input  logic               re_fall,
  output logic               busy,
  output logic               rd_fire,
  output logic [COL_W-1:0]   rd_col,
  output logic [PAGE_AW-1:0] rd_page,
  output logic               rgn_spare
);
  localparam int CNT_W = $clog2(TR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TR_CYCLES - 1);

  rd_state_e          st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [COL_W-1:0]   col_q;
  logic [PAGE_AW-1:0] page_q;
  logic               spare_q;
  logic               at_end, final_page;

  assign at_end     = (col_q == COL_W'(LAST_COL));
  assign final_page = &page_q;
  assign rd_fire    = (st_q == ST_READ) & re_fall & ~ce_n;
  assign busy       = (st_q == ST_BUSY);
  assign rd_col     = col_q;
  assign rd_page    = page_q;
  assign rgn_spare  = spare_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      col_q   <= '0;
      page_q  <= '0;
      spare_q <= 1'b0;
    end else if (ce_n || cmd_hit) begin
      st_q <= ST_IDLE;
    end else if (start_go) begin
      st_q    <= ST_BUSY;
      cnt_q   <= CNT_LOAD;
      col_q   <= start_col;
      page_q  <= start_page;
      spare_q <= spare_mode;
    end else begin
      unique case (st_q)
        ST_BUSY: begin
          if (cnt_q == '0) st_q <= ST_READ;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_READ: begin
          if (rd_fire) begin
            if (!at_end) begin
              col_q <= col_q + 1'b1;
            end else if (!final_page) begin
              page_q <= page_q + 1'b1;
              col_q  <= spare_q ? COL_W'(SPARE_BASE) : '0;
              st_q   <= ST_BUSY;
              cnt_q  <= CNT_LOAD;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nand_page_store.sv
module nand_page_store
  import nand_rd_pkg::*;
#(
  parameter int PAGE_AW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_fire,
  input  logic [COL_W-1:0]   rd_col,
  input  logic [PAGE_AW-1:0] rd_page,
  output logic [7:0]         dout,
  output logic               dout_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout       <= 8'h00;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= rd_fire;
      if (rd_fire) dout <= cell_byte(4'(rd_page), rd_col);
    end
  end
endmodule

// File: rtl/nand_read_ptr_ctrl.sv
module nand_read_ptr_ctrl
  import nand_rd_pkg::*;
#(
  parameter int PAGE_AW   = 2,
  parameter int TR_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic [7:0] io_in,
  output logic       rb_n,
  output logic [7:0] dout,
  output logic       dout_valid
);
  logic [1:0]         rise2, fall2;
  logic               we_rise, re_fall;
  logic               cmd_hit, start_go, spare_mode, busy, rd_fire, ptr_spare;
  logic [COL_W-1:0]   start_col, rd_col;
  logic [PAGE_AW-1:0] start_page, rd_page;

  nand_strobe_edge #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .strobe_n({re_n, we_n}), .rise(rise2), .fall(fall2)
  );
  assign we_rise = rise2[0];
  assign re_fall = fall2[1];

  nand_cmd_decode #(.PAGE_AW(PAGE_AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_rise(we_rise),
    .io_in(io_in), .busy(busy), .cmd_hit(cmd_hit), .start_go(start_go),
    .start_col(start_col), .start_page(start_page), .spare_mode(spare_mode)
  );

  nand_col_ptr #(.PAGE_AW(PAGE_AW), .TR_CYCLES(TR_CYCLES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cmd_hit(cmd_hit), .start_go(start_go),
    .start_col(start_col), .start_page(start_page), .spare_mode(spare_mode),
    .re_fall(re_fall), .busy(busy), .rd_fire(rd_fire), .rd_col(rd_col),
    .rd_page(rd_page), .rgn_spare(ptr_spare)
  );

  nand_page_store #(.PAGE_AW(PAGE_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .rd_col(rd_col), .rd_page(rd_page),
    .dout(dout), .dout_valid(dout_valid)
  );

  assign rb_n = ~busy;
endmodule

// File: rtl/nand_read_ptr_ctrl_chk.sv
module nand_read_ptr_ctrl_chk #(
  parameter int PAGE_AW = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ce_n,
  input logic               rb_n,
  input logic               dout_valid,
  input logic               rd_fire,
  input logic [9:0]         rd_col,
  input logic [PAGE_AW-1:0] rd_page,
  input logic               spare_q,
  input logic               start_go
);
  AST_NO_DATA_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> $past(rb_n)); // R6
  AST_DESELECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> !$past(ce_n)); // R10
  AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> rd_col <= 10'd527); // R7
  AST_SPARE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && spare_q) |-> rd_col >= 10'd512); // R5
  AST_BUSY_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> !rb_n); // R6
  AST_ROLL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && rd_col == 10'd527 && rd_page != '1) |=> !rb_n); // R8
  AST_LAST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && rd_col == 10'd527 && rd_page == '1) |=> rb_n); // R9
endmodule

bind nand_read_ptr_ctrl nand_read_ptr_ctrl_chk #(.PAGE_AW(PAGE_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rb_n(rb_n), .dout_valid(dout_valid),
  .rd_fire(rd_fire), .rd_col(rd_col), .rd_page(rd_page), .spare_q(ptr_spare),
  .start_go(start_go)
);

// File: tb/nand_read_ptr_ctrl_bench.sv
module nand_read_ptr_ctrl_bench;
  localparam int TR = 20;
  localparam int PAW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic rb_n, dout_valid;
  logic [7:0] dout;
  int n_cmp = 0, n_bad = 0;
  logic v;
  logic [7:0] d;
  int cyc;

  always #4 clk = ~clk;

  nand_read_ptr_ctrl #(.PAGE_AW(PAW), .TR_CYCLES(TR)) u_nand_read_ptr_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .io_in(io_in), .rb_n(rb_n), .dout(dout), .dout_valid(dout_valid)
  );

  // {cmd, column byte, row low, expected start column, expected page}
  localparam logic [43:0] VEC [6] = '{
    44'h00_05_01_0005_1,   // R3 lower half
    44'h01_10_02_0110_2,   // R3 upper half
    44'h50_F3_00_0203_0,   // R4 high nibble ignored
    44'h01_00_03_0200_3,   // R5 01 keeps spare
    44'h00_2A_00_002A_0,   // R5 00 leaves spare
    44'h00_FF_06_00FF_2    // R2 row wraps onto page bits
  };

  function automatic logic [7:0] exp_byte(input int pg, input int col);
    logic [9:0] c;
    logic [3:0] p;
    c = 10'(col);
    p = 4'(pg);
    return c[7:0] ^ {p, 2'b00, c[9:8]};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic strobe_byte(input logic is_cmd, input logic [7:0] b);
    @(negedge clk); cle = is_cmd; ale = ~is_cmd; io_in = b; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask

  task automatic issue(input logic [7:0] c, input logic [7:0] col, input logic [7:0] rlo);
    strobe_byte(1'b1, c);
    strobe_byte(1'b0, col);
    strobe_byte(1'b0, rlo);
    strobe_byte(1'b0, 8'h00);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (rb_n === 1'b0 && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic re_pulse(output logic vo, output logic [7:0] dv);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); vo = dout_valid; dv = dout; re_n = 1'b1;
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rb_n", int'(rb_n), 1);
    check("R1 dout_valid", int'(dout_valid), 0);
    check("R1 dout", int'(dout), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R3, R4, R5, R6, R7
    for (int i = 0; i < 6; i++) begin
      logic [43:0] e;
      e = VEC[i];
      issue(e[43:36], e[35:28], e[27:20]);
      check("R6 busy after address", int'(rb_n), 0);
      wait_ready(cyc);
      check("R6 busy length", cyc, TR);
      for (int j = 0; j < 3; j++) begin
        re_pulse(v, d);
        check("R7 valid", int'(v), 1);
        check("R3/R4/R5 byte", int'(d), int'(exp_byte(int'(e[3:0]), int'(e[19:4]) + j)));
      end
    end

    // R6: read strobe during busy ignored, pointer unmoved
    issue(8'h00, 8'h03, 8'h00);
    re_pulse(v, d);
    check("R6 no data while busy", int'(v), 0);
    wait_ready(cyc);
    re_pulse(v, d);
    check("R6 pointer unmoved", int'(d), int'(exp_byte(0, 3)));

    // R2: unknown command and its address bytes change nothing
    issue(8'h90, 8'h40, 8'h01);
    check("R2 unknown cmd no busy", int'(rb_n), 1);
    re_pulse(v, d);
    check("R2 read continues", int'(d), int'(exp_byte(0, 4)));

    // R8: main-area rollover from upper half
    issue(8'h01, 8'hFF, 8'h00);
    wait_ready(cyc);
    for (int j = 0; j < 17; j++) begin
      re_pulse(v, d);
      check("R7 run to 527", int'(d), int'(exp_byte(0, 511 + j)));
    end
    check("R8 busy on rollover", int'(rb_n), 0);
    wait_ready(cyc);
    check("R8 rollover busy length", cyc, TR);
    re_pulse(v, d);
    check("R8 main restart col 0", int'(d), int'(exp_byte(1, 0)));

    // R8: spare rollover restarts at 512
    issue(8'h50, 8'h0D, 8'h01);
    wait_ready(cyc);
    for (int j = 0; j < 3; j++) begin
      re_pulse(v, d);
      check("R4 spare run", int'(d), int'(exp_byte(1, 525 + j)));
    end
    check("R8 spare busy", int'(rb_n), 0);
    wait_ready(cyc);
    re_pulse(v, d);
    check("R8 spare restart 512", int'(d), int'(exp_byte(2, 512)));

    // R9: freeze on last page
    issue(8'h50, 8'h0E, 8'h03);
    wait_ready(cyc);
    re_pulse(v, d);
    check("R9 col 526", int'(d), int'(exp_byte(3, 526)));
    for (int j = 0; j < 3; j++) begin
      re_pulse(v, d);
      check("R9 repeat 527", int'(d), int'(exp_byte(3, 527)));
      check("R9 stays ready", int'(rb_n), 1);
    end

    // R10: deselect aborts; strobes ignored while deselected
    issue(8'h00, 8'h10, 8'h00);
    wait_ready(cyc);
    @(negedge clk); ce_n = 1'b1;
    re_pulse(v, d);
    check("R10 no data deselected", int'(v), 0);
    issue(8'h00, 8'h20, 8'h01);
    check("R10 WE ignored deselected", int'(rb_n), 1);
    @(negedge clk); ce_n = 1'b0;
    re_pulse(v, d);
    check("R10 idle after abort", int'(v), 0);
    check("R10 ready after abort", int'(rb_n), 1);

    report();
  end
endmodule